// File: doc/BRIEF.md
# Dirty-Page Log Drain Engine

This block empties a hardware dirty-page log held in memory. The log is a buffer of `ENTRY_CNT` 64-bit slots. The filling side counts its slot index downward from the top slot, so the index always names the next free slot. When a flush is requested, the engine works out which slots hold entries from the index value. It then reads those slots one at a time, lowest first, and hands each entry downstream as a page frame number on a valid/ready stream.

After the top slot has been handed over, the engine writes the index back to its empty value on a one-cycle write strobe. It then pulses a done signal. An entry that is not page aligned raises a sticky warning flag, but it is still forwarded after the shift. Only one read is outstanding at a time. No new read starts while a frame number waits at the output.

Top module: `log_drain_engine`

## Requirements
- R1: After synchronous reset, `rd_req_valid`, `pfn_valid`, `idx_wr_en`, `flush_done` and `misalign_warn` are all 0.
- R2: A flush accepted with `cur_index` equal to `ENTRY_CNT-1` issues no read and emits no frame number. It strobes `idx_wr_en` in the cycle after acceptance.
- R3: A flush accepted with `cur_index` of `ENTRY_CNT` or more drains every slot, beginning at slot 0.
- R4: Any other `cur_index` value starts the drain at slot `cur_index+1`.
- R5: Slots are read one at a time in ascending order, up to and including slot `ENTRY_CNT-1`. The read address is `buf_base + 8*slot`. A pending request holds its address until `rd_req_ready`.
- R6: Each returned entry is emitted as `pfn_data = entry >> 12`, in slot order.
- R7: `misalign_warn` sets when any drained entry has a nonzero value in bits [11:0]. It is cleared only when a flush is accepted. The misaligned entry is still emitted.
- R8: While `pfn_valid` is high and `pfn_ready` is low, `pfn_data` stays stable and no read request is raised.
- R9: After the last frame number is accepted, `idx_wr_en` pulses for one cycle with `idx_wr_data` equal to `ENTRY_CNT-1`. `flush_done` pulses in the cycle right after it, in the empty case too.
- R10: `flush_start` is ignored while a flush is in progress, including the cycle in which `flush_done` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| flush_start | input | 1 | Flush request strobe, sampled while idle |
| cur_index | input | 16 | Current log index (next free slot) |
| buf_base | input | 64 | Byte base address of the log buffer |
| rd_req_valid | output | 1 | Memory read request valid |
| rd_req_ready | input | 1 | Memory read request accepted |
| rd_req_addr | output | 64 | Memory read byte address |
| rd_rsp_valid | input | 1 | Read data return valid |
| rd_rsp_data | input | 64 | Read data return |
| pfn_valid | output | 1 | Frame number stream valid |
| pfn_ready | input | 1 | Frame number stream ready |
| pfn_data | output | 52 | Page frame number |
| idx_wr_en | output | 1 | Index write-back strobe |
| idx_wr_data | output | 16 | Index write-back value |
| flush_done | output | 1 | Flush complete pulse |
| misalign_warn | output | 1 | Sticky misaligned-entry flag |

## Verification
Two events can meet in one cycle: the done pulse of one flush and a new flush strobe. The bench raises `flush_start` in exactly the cycle it sees `flush_done` high. It then requires no read request and no second done in the cycles that follow. In the empty case the index write-back and the done pulse come right after acceptance, so the strobe that the bench injects one cycle later lands in the done cycle as well. The bench also sweeps every index value of a 16-slot configuration under three backpressure and read-latency patterns. Frame numbers and warning state are predicted arithmetically from each slot's generated content.

// File: rtl/ldd_pkg.sv
package ldd_pkg;
    localparam int IDX_W      = 16;
    localparam int DATA_W     = 64;
    localparam int ADDR_W     = 64;
    localparam int PAGE_SHIFT = 12;
    localparam int PFN_W      = DATA_W - PAGE_SHIFT;
    localparam int SLOT_LOG2  = 3;

    typedef enum logic [2:0] {
        S_IDLE,
        S_REQ,
        S_WAIT,
        S_EMIT,
        S_WB,
        S_DONE
    } drain_state_e;

    typedef struct packed {
        logic [PFN_W-1:0] pfn;
        logic             misaligned;
    } drain_beat_t;

    function automatic drain_beat_t split_entry(input logic [DATA_W-1:0] e);
        drain_beat_t b;
        b.pfn        = e[DATA_W-1:PAGE_SHIFT];
        b.misaligned = |e[PAGE_SHIFT-1:0];
        return b;
    endfunction
endpackage

// File: rtl/ldd_range.sv
module ldd_range
    import ldd_pkg::*;
#(
    parameter int ENTRY_CNT = 512,
    parameter int CUR_W     = $clog2(ENTRY_CNT)
) (
    input  logic [IDX_W-1:0] index,
    output logic             empty,
    output logic [CUR_W-1:0] first
);
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(ENTRY_CNT - 1);
    localparam logic [IDX_W-1:0] CNT_IDX  = IDX_W'(ENTRY_CNT);

    logic [IDX_W-1:0] next_slot;

    always_comb begin
        next_slot = index + IDX_W'(1);
        empty     = (index == LAST_IDX);
        if (index >= CNT_IDX) begin
            first = '0;
        end else if (empty) begin
            first = CUR_W'(ENTRY_CNT - 1);
        end else begin
            first = next_slot[CUR_W-1:0];
        end
    end
endmodule

// File: rtl/ldd_addr_gen.sv
module ldd_addr_gen
    import ldd_pkg::*;
#(
    parameter int ENTRY_CNT = 512,
    parameter int CUR_W     = $clog2(ENTRY_CNT)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic              advance,
    input  logic [ADDR_W-1:0] base_in,
    input  logic [CUR_W-1:0]  first_in,
    output logic [ADDR_W-1:0] addr,
    output logic              at_last
);
    localparam logic [CUR_W-1:0] LAST_SLOT = CUR_W'(ENTRY_CNT - 1);

    logic [ADDR_W-1:0] base_q;
    logic [CUR_W-1:0]  cur_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            base_q <= '0;
            cur_q  <= '0;
        end else if (load) begin
            base_q <= base_in;
            cur_q  <= first_in;
        end else if (advance) begin
            cur_q  <= cur_q + CUR_W'(1);
        end
    end

    always_comb begin
        addr    = base_q + (ADDR_W'(cur_q) << SLOT_LOG2);
        at_last = (cur_q == LAST_SLOT);
    end

    // R5
    no_advance_past_end_chk: assert property (@(posedge clk) disable iff (rst)
        advance |-> !at_last);
endmodule

// File: rtl/ldd_out_stage.sv
module ldd_out_stage
    import ldd_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              clr_warn,
    input  logic              cap,
    input  logic [DATA_W-1:0] cap_data,
    input  logic              out_ready,
    output logic              out_valid,
    output logic [PFN_W-1:0]  out_pfn,
    output logic              warn
);
    drain_beat_t beat_q;
    drain_beat_t beat_d;
    logic        valid_q;
    logic        warn_q;

    always_comb beat_d = split_entry(cap_data);

    always_ff @(posedge clk) begin
        if (rst) begin
            beat_q  <= '0;
            valid_q <= 1'b0;
            warn_q  <= 1'b0;
        end else begin
            if (cap) begin
                beat_q  <= beat_d;
                valid_q <= 1'b1;
            end else if (valid_q && out_ready) begin
                valid_q <= 1'b0;
            end
            if (clr_warn) begin
                warn_q <= 1'b0;
            end else if (cap && beat_d.misaligned) begin
                warn_q <= 1'b1;
            end
        end
    end

    assign out_valid = valid_q;
    assign out_pfn   = beat_q.pfn;
    assign warn      = warn_q;

    // R8
    pfn_hold_chk: assert property (@(posedge clk) disable iff (rst)
        out_valid && !out_ready |=> out_valid && $stable(out_pfn));

    // R7
    warn_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        warn && !clr_warn |=> warn);
endmodule

// File: rtl/log_drain_engine.sv
module log_drain_engine
    import ldd_pkg::*;
#(
    parameter int ENTRY_CNT = 512
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              flush_start,
    input  logic [IDX_W-1:0]  cur_index,
    input  logic [ADDR_W-1:0] buf_base,
    output logic              rd_req_valid,
    input  logic              rd_req_ready,
    output logic [ADDR_W-1:0] rd_req_addr,
    input  logic              rd_rsp_valid,
    input  logic [DATA_W-1:0] rd_rsp_data,
    output logic              pfn_valid,
    input  logic              pfn_ready,
    output logic [PFN_W-1:0]  pfn_data,
    output logic              idx_wr_en,
    output logic [IDX_W-1:0]  idx_wr_data,
    output logic              flush_done,
    output logic              misalign_warn
);
    localparam int CUR_W = $clog2(ENTRY_CNT);

    drain_state_e     state_q;
    drain_state_e     state_d;
    logic             accept;
    logic             range_empty;
    logic [CUR_W-1:0] range_first;
    logic             at_last;
    logic             advance;
    logic             capture;
    logic             handed_over;

    ldd_range #(.ENTRY_CNT(ENTRY_CNT), .CUR_W(CUR_W)) u_range (
        .index (cur_index),
        .empty (range_empty),
        .first (range_first)
    );

    ldd_addr_gen #(.ENTRY_CNT(ENTRY_CNT), .CUR_W(CUR_W)) u_addr (
        .clk      (clk),
        .rst      (rst),
        .load     (accept),
        .advance  (advance),
        .base_in  (buf_base),
        .first_in (range_first),
        .addr     (rd_req_addr),
        .at_last  (at_last)
    );

    ldd_out_stage u_out (
        .clk       (clk),
        .rst       (rst),
        .clr_warn  (accept),
        .cap       (capture),
        .cap_data  (rd_rsp_data),
        .out_ready (pfn_ready),
        .out_valid (pfn_valid),
        .out_pfn   (pfn_data),
        .warn      (misalign_warn)
    );

    always_comb begin
        accept      = (state_q == S_IDLE) && flush_start;
        capture     = (state_q == S_WAIT) && rd_rsp_valid;
        handed_over = (state_q == S_EMIT) && pfn_valid && pfn_ready;
        advance     = handed_over && !at_last;
        state_d     = state_q;
        unique case (state_q)
            S_IDLE: if (accept)       state_d = range_empty ? S_WB : S_REQ;
            S_REQ:  if (rd_req_ready) state_d = S_WAIT;
            S_WAIT: if (rd_rsp_valid) state_d = S_EMIT;
            S_EMIT: if (handed_over)  state_d = at_last ? S_WB : S_REQ;
            S_WB:                     state_d = S_DONE;
            S_DONE:                   state_d = S_IDLE;
            default:                  state_d = S_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) state_q <= S_IDLE;
        else     state_q <= state_d;
    end

    assign rd_req_valid = (state_q == S_REQ);
    assign idx_wr_en    = (state_q == S_WB);
    assign idx_wr_data  = IDX_W'(ENTRY_CNT - 1);
    assign flush_done   = (state_q == S_DONE);

    // R9
    done_after_wb_chk: assert property (@(posedge clk) disable iff (rst)
        idx_wr_en |=> flush_done);

    // R9
    wb_before_done_chk: assert property (@(posedge clk) disable iff (rst)
        flush_done |-> $past(idx_wr_en));

    // R8
    no_read_while_held_chk: assert property (@(posedge clk) disable iff (rst)
        pfn_valid |-> !rd_req_valid);

    // R5
    req_stable_chk: assert property (@(posedge clk) disable iff (rst)
        rd_req_valid && !rd_req_ready |=> rd_req_valid && $stable(rd_req_addr));

    // R10
    done_start_ignored_chk: assert property (@(posedge clk) disable iff (rst)
        flush_done |=> !rd_req_valid && !idx_wr_en);

    // R2
    empty_no_read_chk: assert property (@(posedge clk) disable iff (rst)
        accept && range_empty |=> idx_wr_en && !rd_req_valid);
endmodule

// File: tb/log_drain_engine_tb.sv
`timescale 1ns/1ps
module log_drain_engine_tb;
    localparam int N = 16;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        flush_start = 1'b0;
    logic [15:0] cur_index = '0;
    logic [63:0] buf_base = '0;
    logic        rd_req_valid;
    logic        rd_req_ready = 1'b0;
    logic [63:0] rd_req_addr;
    logic        rd_rsp_valid = 1'b0;
    logic [63:0] rd_rsp_data = '0;
    logic        pfn_valid;
    logic        pfn_ready = 1'b0;
    logic [51:0] pfn_data;
    logic        idx_wr_en;
    logic [15:0] idx_wr_data;
    logic        flush_done;
    logic        misalign_warn;

    int vec_n = 0;
    int fail_n = 0;
    int cyc = 0;
    int mode = 0;
    logic [63:0] run_base = '0;
    int run_mis = -1;
    int exp_first = 0;
    int exp_cnt = 0;
    int acc_i = 0, acc_n = 0, rd_i = 0, wb_n = 0, done_n = 0;
    logic pend = 1'b0;
    int pend_cnt = 0;
    int pend_i = 0;
    logic prev_stall = 1'b0;
    logic [51:0] prev_pfn = '0;
    logic prev_wb = 1'b0;

    always #2 clk = ~clk;

    log_drain_engine #(.ENTRY_CNT(N)) u_dut (
        .clk(clk), .rst(rst), .flush_start(flush_start), .cur_index(cur_index),
        .buf_base(buf_base), .rd_req_valid(rd_req_valid), .rd_req_ready(rd_req_ready),
        .rd_req_addr(rd_req_addr), .rd_rsp_valid(rd_rsp_valid), .rd_rsp_data(rd_rsp_data),
        .pfn_valid(pfn_valid), .pfn_ready(pfn_ready), .pfn_data(pfn_data),
        .idx_wr_en(idx_wr_en), .idx_wr_data(idx_wr_data), .flush_done(flush_done),
        .misalign_warn(misalign_warn)
    );

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        vec_n++;
        if (act !== exp) begin
            fail_n++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [63:0] entry_val(input int i);
        logic [63:0] v;
        v = ((run_base >> 12) + 64'h5A00 + 64'(i) * 64'd3) << 12;
        if (i == run_mis) v = v | 64'h801;
        return v;
    endfunction

    // memory model, stream sink and monitor
    always @(negedge clk) begin
        cyc++;
        if (rst) begin
            rd_req_ready = 1'b0;
            pfn_ready    = 1'b0;
            rd_rsp_valid = 1'b0;
            pend         = 1'b0;
            prev_stall   = 1'b0;
            prev_wb      = 1'b0;
        end else begin
            rd_req_ready = (mode == 0) ? 1'b1 : ((cyc % 3) != 1);
            pfn_ready    = (mode == 0) ? 1'b1 : (mode == 1) ? ((cyc % 4) != 0) : ((cyc % 5) < 2);
            rd_rsp_valid = 1'b0;
            if (pend) begin
                if (pend_cnt <= 1) begin
                    rd_rsp_valid = 1'b1;
                    rd_rsp_data  = entry_val(pend_i);
                    pend = 1'b0;
                end else begin
                    pend_cnt--;
                end
            end
            if (rd_req_valid && rd_req_ready) begin
                chk("R5 read address", rd_req_addr, run_base + 64'(rd_i) * 64'd8);
                pend_i   = int'((rd_req_addr - run_base) >> 3);
                pend     = 1'b1;
                pend_cnt = (mode == 2) ? 2 : 1;
                rd_i++;
            end
            if (pfn_valid) begin
                if (prev_stall) chk("R8 held pfn", 64'(pfn_data), 64'(prev_pfn));
                if (pfn_ready) begin
                    chk("R6 pfn value", 64'(pfn_data), entry_val(acc_i) >> 12);
                    acc_i++;
                    acc_n++;
                end
            end
            prev_stall = pfn_valid && !pfn_ready;
            prev_pfn   = pfn_data;
            if (flush_done) begin
                chk("R9 done follows write-back", 64'(prev_wb), 64'd1);
                done_n++;
            end
            if (idx_wr_en) begin
                chk("R9 write-back value", 64'(idx_wr_data), 64'(N - 1));
                chk("R9 all drained before write-back", 64'(acc_n), 64'(exp_cnt));
                wb_n++;
            end
            prev_wb = idx_wr_en;
        end
    end

    task automatic run_flush(input logic [15:0] idx, input int mis, input int md);
        int k;
        logic seen;
        logic exp_warn;
        mode     = md;
        run_base = 64'h0000_0012_3450_0000 + (64'(idx) << 12);
        run_mis  = mis;
        if (idx == 16'(N - 1)) begin
            exp_first = N - 1;
            exp_cnt   = 0;
        end else if (idx >= 16'(N)) begin
            exp_first = 0;
            exp_cnt   = N;
        end else begin
            exp_first = int'(idx) + 1;
            exp_cnt   = N - exp_first;
        end
        exp_warn = (exp_cnt > 0) && (mis >= exp_first) && (mis < N);
        acc_i = exp_first; rd_i = exp_first;
        acc_n = 0; wb_n = 0; done_n = 0;
        @(negedge clk);
        flush_start = 1'b1; cur_index = idx; buf_base = run_base;
        @(negedge clk);
        flush_start = 1'b0; cur_index = 16'h0;
        k = 0; seen = 1'b0;
        while (!seen && k < 3000) begin
            @(negedge clk);
            k++;
            flush_start = 1'b0;
            if (flush_done) begin
                seen = 1'b1;
                flush_start = 1'b1;   // R10: strobe in the done cycle
                cur_index = 16'h0;
            end else if (k == 1) begin
                flush_start = 1'b1;   // R10: strobe while busy
                cur_index = 16'h0;
            end
        end
        @(negedge clk);
        flush_start = 1'b0;
        if (!seen) begin
            vec_n++; fail_n++;
            $display("FAIL R9 timeout idx=%0d actual=no done expected=done", idx);
        end
        for (int t = 0; t < 6; t++) begin
            @(negedge clk);
            chk("R10 no read after ignored strobe", 64'(rd_req_valid), 64'd0);
        end
        chk("R10 single done", 64'(done_n), 64'd1);
        chk("R9 single write-back", 64'(wb_n), 64'd1);
        if (exp_cnt == 0) chk("R2 empty emits nothing", 64'(acc_n), 64'd0);
        else if (idx >= 16'(N)) chk("R3 full drain count", 64'(acc_n), 64'(exp_cnt));
        else chk("R4 partial drain count", 64'(acc_n), 64'(exp_cnt));
        chk("R5 read count", 64'(rd_i - exp_first), 64'(exp_cnt));
        chk("R7 warning flag", 64'(misalign_warn), 64'(exp_warn));
    endtask

    initial begin
        #700000;
        vec_n++; fail_n++;
        $display("FAIL watchdog actual=hung expected=finished");
        $display("== %0d vectors applied, %0d miscompares ==", vec_n, fail_n);
        $finish;
    end

    initial begin
        repeat (5) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk("R1 rd_req_valid", 64'(rd_req_valid), 64'd0);
        chk("R1 pfn_valid", 64'(pfn_valid), 64'd0);
        chk("R1 idx_wr_en", 64'(idx_wr_en), 64'd0);
        chk("R1 flush_done", 64'(flush_done), 64'd0);
        chk("R1 misalign_warn", 64'(misalign_warn), 64'd0);
        for (int md = 0; md < 3; md++) begin
            for (int ix = 0; ix < N + 3; ix++) begin
                run_flush(16'(ix), (ix * 5 + md) % (N + 3), md);
            end
            run_flush(16'hFFFF, md + 2, md);
            run_flush(16'h0, -1, md);   // R7: cleared by next accepted flush
        end
        $display("== %0d vectors applied, %0d miscompares ==", vec_n, fail_n);
        $finish;
    end
endmodule